// File: doc/BRIEF.md
# Receive Byte Queue with Threshold and Idle Timeout

This block holds received bytes between the channel router and software. The router offers one byte per cycle on a push strobe. Software takes the oldest byte by raising a pop strobe while it reads the data output. The block keeps a write pointer and an occupancy count, and it derives the oldest-entry position from those two. It gives the interrupt block three level flags: threshold reached, empty and full. It also gives two single-cycle events: overrun, when a byte arrives with no room, and idle timeout, when no byte has arrived for a fixed number of character periods.

Character periods come from an external tick that pulses once per character time. A receiver-active input gates both sides of the queue. A flush input empties the queue whether or not the receiver is active. The threshold is a small register, written through a strobe and value pair.

Top module: `rxq_buffer`

## Requirements
- R1: After reset the empty flag is 1, the full flag, the threshold flag and both event outputs are 0, popData is 0, and the threshold register holds 32. At that threshold, sixteen stored bytes leave the threshold flag at 0.
- R2: While the receiver is active, up to 16 pushed bytes are stored. They come out on popData in arrival order, and popData shows the oldest byte during the cycle its pop strobe is high.
- R3: The full flag rises on the push that brings the count to 16, and any accepted pop clears it. Full and empty are never both high.
- R4: A push while 16 bytes are held, with no pop in the same cycle, is not stored. It raises overrunPulse for exactly one cycle, in the cycle after that push.
- R5: The threshold flag sets when a push leaves the count at or above the threshold register. It clears when a pop leaves the count below it. Writing the threshold register alone does not change the flag.
- R6: A pop while the queue is empty reads 0 and leaves empty at 1. The pop that removes the last byte sets empty to 1. Whenever empty is 1, popData is 0.
- R7: A push and a pop in the same cycle with at least one byte held leaves the count unchanged, returns the oldest byte and stores the new one. With the queue empty, the pop reads 0 and the byte is stored.
- R8: Every accepted push restarts the idle timer. The fourth charTick after the last accepted push, with no push in between, raises timeoutPulse for one cycle, in the cycle after that tick. It does not fire again until another push.
- R9: While rxActive is 0, pushes and pops have no effect: nothing is stored or removed, no overrun is raised, and popData is 0.
- R10: A flush empties the queue, clears full and threshold, and cancels a pending timeout, even while rxActive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxActive | input | 1 | Receiver enabled; gates push and pop |
| rxFlush | input | 1 | Empty the queue and cancel the timer |
| pushValid | input | 1 | A byte is offered by the router |
| pushByte | input | 8 | Byte offered by the router |
| popStrobe | input | 1 | Software takes the oldest byte |
| popData | output | 8 | Oldest byte, or 0 when none is available |
| thrWrite | input | 1 | Load the threshold register |
| thrValue | input | 6 | New threshold value |
| charTick | input | 1 | One pulse per character period |
| trigLevel | output | 1 | Count reached the threshold |
| emptyLevel | output | 1 | Queue is empty |
| fullLevel | output | 1 | Queue holds 16 bytes |
| overrunPulse | output | 1 | Byte lost because the queue was full |
| timeoutPulse | output | 1 | Idle timeout event |

## Verification
The embedded properties guard the invariants on every cycle. The count never passes 16, full and empty are exclusive, and popData is 0 whenever empty is set. An overrun event only follows a full cycle. The timeout event lasts one cycle and follows a tick. Nothing moves while the receiver is inactive. Only the directed scenarios show the rest: that bytes leave in arrival order, that the lost byte really is absent, that the flag responds to threshold changes only on the next push or pop, and that restarting the timer and refusing to refire work over many ticks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int RXQ_DEPTH = 16;
  parameter int RXQ_DATA_W = 8;
  localparam int RXQ_PTR_W = $clog2(RXQ_DEPTH);
  localparam int RXQ_CNT_W = RXQ_PTR_W + 1;

  // Strobes from control to storage.
  typedef struct packed {
    logic                 wrEn;
    logic [RXQ_PTR_W-1:0] wrAddr;
    logic [RXQ_PTR_W-1:0] rdAddr;
    logic                 showHead;
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = RXQ_DATA_W
) (
  input  logic              clk,
  input  rxq_strobe_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] slots [RXQ_DEPTH];

  for (genvar g = 0; g < RXQ_DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (strobes.wrAddr == RXQ_PTR_W'(g))) slots[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.showHead) rdData = slots[strobes.rdAddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int THR_W = 6,
  parameter logic [THR_W-1:0] THR_RESET = THR_W'(32),
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxActive,
  input  logic             rxFlush,
  input  logic             pushValid,
  input  logic             popStrobe,
  input  logic             thrWrite,
  input  logic [THR_W-1:0] thrValue,
  input  logic             charTick,
  output rxq_strobe_t      strobes,
  output logic             trigLevel,
  output logic             emptyLevel,
  output logic             fullLevel,
  output logic             overrunPulse,
  output logic             timeoutPulse
);
  localparam int CMP_W = (RXQ_CNT_W > THR_W) ? RXQ_CNT_W : THR_W;
  localparam int TO_W  = $clog2(TIMEOUT_CHARS + 1);

  logic [RXQ_CNT_W-1:0] countQ, nextCount;
  logic [RXQ_PTR_W-1:0] wptrQ;
  logic [THR_W-1:0]     thrQ;
  logic [TO_W-1:0]      timerQ;
  logic armedQ, trigQ, emptyQ, fullQ, overrunQ, timeoutQ;
  logic popAcc, popTakes, pushAcc, pushTry, atDepth, atThr;

  assign atDepth  = (countQ == RXQ_CNT_W'(RXQ_DEPTH));
  assign popAcc   = rxActive && popStrobe && !rxFlush;
  assign popTakes = popAcc && (countQ != '0);
  assign pushTry  = rxActive && pushValid && !rxFlush;
  assign pushAcc  = pushTry && (!atDepth || popTakes);
  assign nextCount = countQ + RXQ_CNT_W'(pushAcc) - RXQ_CNT_W'(popTakes);
  assign atThr    = (CMP_W'(nextCount) >= CMP_W'(thrQ));

  always_comb begin
    strobes.wrEn     = pushAcc;
    strobes.wrAddr   = wptrQ;
    strobes.rdAddr   = wptrQ - countQ[RXQ_PTR_W-1:0];
    strobes.showHead = rxActive && (countQ != '0);
  end

  // Occupancy, pointer and level flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      wptrQ  <= '0;
      emptyQ <= 1'b1;
      fullQ  <= 1'b0;
      trigQ  <= 1'b0;
    end else if (rxFlush) begin
      countQ <= '0;
      wptrQ  <= '0;
      emptyQ <= 1'b1;
      fullQ  <= 1'b0;
      trigQ  <= 1'b0;
    end else begin
      countQ <= nextCount;
      if (pushAcc) wptrQ <= wptrQ + 1'b1;
      if (pushAcc) begin
        emptyQ <= 1'b0;
        fullQ  <= (nextCount == RXQ_CNT_W'(RXQ_DEPTH));
      end else if (popAcc) begin
        emptyQ <= (nextCount == '0);
        fullQ  <= 1'b0;
      end
      if (pushAcc && atThr) trigQ <= 1'b1;
      else if (popAcc && !atThr) trigQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) thrQ <= THR_RESET;
    else if (thrWrite) thrQ <= thrValue;
  end

  // Idle timer in character periods.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ   <= 1'b0;
      timerQ   <= '0;
      timeoutQ <= 1'b0;
      overrunQ <= 1'b0;
    end else begin
      overrunQ <= pushTry && !pushAcc;
      timeoutQ <= !rxFlush && !pushAcc && armedQ && charTick && (timerQ == TO_W'(1));
      if (rxFlush) begin
        armedQ <= 1'b0;
      end else if (pushAcc) begin
        armedQ <= 1'b1;
        timerQ <= TO_W'(TIMEOUT_CHARS);
      end else if (armedQ && charTick) begin
        timerQ <= timerQ - 1'b1;
        if (timerQ == TO_W'(1)) armedQ <= 1'b0;
      end
    end
  end

  assign trigLevel    = trigQ;
  assign emptyLevel   = emptyQ;
  assign fullLevel    = fullQ;
  assign overrunPulse = overrunQ;
  assign timeoutPulse = timeoutQ;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= RXQ_CNT_W'(RXQ_DEPTH));
  assert_full_not_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(fullQ && emptyQ));
  assert_overrun_after_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    overrunQ |-> $past(fullQ));
  assert_timeout_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutQ |=> !timeoutQ);
  assert_timeout_on_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutQ |-> $past(charTick));
  assert_idle_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!rxActive && !rxFlush) |=> ($stable(countQ) && $stable(wptrQ)));
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
  import rxq_pkg::*;
#(
  parameter int DATA_W = RXQ_DATA_W,
  parameter int THR_W = 6,
  parameter logic [THR_W-1:0] THR_RESET = THR_W'(32),
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxActive,
  input  logic              rxFlush,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushByte,
  input  logic              popStrobe,
  output logic [DATA_W-1:0] popData,
  input  logic              thrWrite,
  input  logic [THR_W-1:0]  thrValue,
  input  logic              charTick,
  output logic              trigLevel,
  output logic              emptyLevel,
  output logic              fullLevel,
  output logic              overrunPulse,
  output logic              timeoutPulse
);
  rxq_strobe_t strobes;

  rxq_ctrl #(.THR_W(THR_W), .THR_RESET(THR_RESET), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxActive(rxActive), .rxFlush(rxFlush),
    .pushValid(pushValid), .popStrobe(popStrobe), .thrWrite(thrWrite),
    .thrValue(thrValue), .charTick(charTick), .strobes(strobes),
    .trigLevel(trigLevel), .emptyLevel(emptyLevel), .fullLevel(fullLevel),
    .overrunPulse(overrunPulse), .timeoutPulse(timeoutPulse)
  );

  rxq_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .strobes(strobes), .wrData(pushByte), .rdData(popData)
  );

  assert_empty_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    emptyLevel |-> (popData == '0));
endmodule

// File: tb/rxq_buffer_tb.sv
`timescale 1ns/1ps
module rxq_buffer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxActive = 1'b1, rxFlush = 1'b0, pushValid = 1'b0, popStrobe = 1'b0;
  logic thrWrite = 1'b0, charTick = 1'b0;
  logic [7:0] pushByte = '0, popData, lastPop;
  logic [5:0] thrValue = '0;
  logic trigLevel, emptyLevel, fullLevel, overrunPulse, timeoutPulse;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rxq_buffer u_dut (
    .clk(clk), .rstN(rstN), .rxActive(rxActive), .rxFlush(rxFlush),
    .pushValid(pushValid), .pushByte(pushByte), .popStrobe(popStrobe),
    .popData(popData), .thrWrite(thrWrite), .thrValue(thrValue),
    .charTick(charTick), .trigLevel(trigLevel), .emptyLevel(emptyLevel),
    .fullLevel(fullLevel), .overrunPulse(overrunPulse), .timeoutPulse(timeoutPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, sample popData before the rising edge,
  // return just after the rising edge so registered outputs are settled.
  task automatic cyc(input logic pv, input logic [7:0] pb, input logic pp,
                     input logic tk, input logic fl, input logic tw, input logic [5:0] tv);
    @(negedge clk);
    pushValid = pv; pushByte = pb; popStrobe = pp; charTick = tk;
    rxFlush = fl; thrWrite = tw; thrValue = tv;
    #0.5 lastPop = popData;
    @(posedge clk);
    #0.5;
    pushValid = 1'b0; popStrobe = 1'b0; charTick = 1'b0;
    rxFlush = 1'b0; thrWrite = 1'b0;
  endtask

  task automatic push(input logic [7:0] b); cyc(1, b, 0, 0, 0, 0, '0); endtask
  task automatic pop();                      cyc(0, '0, 1, 0, 0, 0, '0); endtask
  task automatic idle();                     cyc(0, '0, 0, 0, 0, 0, '0); endtask
  task automatic tick();                     cyc(0, '0, 0, 1, 0, 0, '0); endtask
  task automatic flush();                    cyc(0, '0, 0, 0, 1, 0, '0); endtask
  task automatic setThr(input logic [5:0] v); cyc(0, '0, 0, 0, 0, 1, v); endtask

  task automatic t_reset();
    chk("R1 empty", emptyLevel, 1);
    chk("R1 full", fullLevel, 0);
    chk("R1 trig", trigLevel, 0);
    chk("R1 overrun", overrunPulse, 0);
    chk("R1 timeout", timeoutPulse, 0);
    chk("R1 popData", popData, 0);
  endtask

  task automatic t_full_overrun();
    for (int i = 0; i < 16; i++) begin
      push(8'h40 + 8'(i));
      if (i == 14) chk("R3 not full at 15", fullLevel, 0);
    end
    chk("R3 full at 16", fullLevel, 1);
    chk("R3 not empty", emptyLevel, 0);
    chk("R1 default threshold keeps trig low", trigLevel, 0);
    push(8'h99);
    chk("R4 overrun pulse", overrunPulse, 1);
    idle();
    chk("R4 overrun one cycle", overrunPulse, 0);
    pop();
    chk("R2 first byte", lastPop, 8'h40);
    chk("R3 pop clears full", fullLevel, 0);
    for (int i = 1; i < 16; i++) begin
      pop();
      chk("R2 order", lastPop, 8'h40 + i);
    end
    chk("R4 lost byte absent, empty", emptyLevel, 1);
  endtask

  task automatic t_order_empty();
    push(8'hA1); push(8'hA2); push(8'hA3);
    pop(); chk("R2 pop 1", lastPop, 8'hA1);
    pop(); chk("R2 pop 2", lastPop, 8'hA2);
    chk("R6 not yet empty", emptyLevel, 0);
    pop(); chk("R2 pop 3", lastPop, 8'hA3);
    chk("R6 last pop sets empty", emptyLevel, 1);
    pop(); chk("R6 empty pop reads 0", lastPop, 0);
    chk("R6 empty stays", emptyLevel, 1);
  endtask

  task automatic t_trigger();
    setThr(6'd3);
    push(8'h10); push(8'h11);
    chk("R5 below threshold", trigLevel, 0);
    push(8'h12);
    chk("R5 reaches threshold", trigLevel, 1);
    setThr(6'd10);
    chk("R5 write alone keeps flag", trigLevel, 1);
    pop();
    chk("R5 pop below clears", trigLevel, 0);
    setThr(6'd2);
    chk("R5 write alone keeps flag low", trigLevel, 0);
    push(8'h13);
    chk("R5 push sets at new threshold", trigLevel, 1);
    flush();
    chk("R10 flush clears trig", trigLevel, 0);
    setThr(6'd32);
  endtask

  task automatic t_simul();
    push(8'h51); push(8'h52);
    cyc(1, 8'h53, 1, 0, 0, 0, '0);
    chk("R7 push+pop returns oldest", lastPop, 8'h51);
    pop(); chk("R7 next", lastPop, 8'h52);
    pop(); chk("R7 new byte kept", lastPop, 8'h53);
    chk("R7 count unchanged then drained", emptyLevel, 1);
    cyc(1, 8'h54, 1, 0, 0, 0, '0);
    chk("R7 empty push+pop reads 0", lastPop, 0);
    chk("R7 empty push+pop stores", emptyLevel, 0);
    pop(); chk("R7 stored byte", lastPop, 8'h54);
  endtask

  task automatic t_timeout();
    push(8'h61);
    for (int i = 0; i < 3; i++) begin tick(); chk("R8 early", timeoutPulse, 0); end
    push(8'h62);
    for (int i = 0; i < 3; i++) begin tick(); chk("R8 restarted", timeoutPulse, 0); end
    tick();
    chk("R8 fires on fourth tick", timeoutPulse, 1);
    idle();
    chk("R8 single cycle", timeoutPulse, 0);
    for (int i = 0; i < 5; i++) begin tick(); chk("R8 no refire", timeoutPulse, 0); end
    flush();
  endtask

  task automatic t_inactive();
    push(8'h21); push(8'h22);
    rxActive = 1'b0;
    pop();
    chk("R9 inactive pop reads 0", lastPop, 0);
    push(8'h23);
    chk("R9 inactive push no overrun", overrunPulse, 0);
    rxActive = 1'b1;
    pop(); chk("R9 nothing removed", lastPop, 8'h21);
    pop(); chk("R9 second kept", lastPop, 8'h22);
    chk("R9 inactive push not stored", emptyLevel, 1);
    for (int i = 0; i < 16; i++) push(8'(i));
    rxActive = 1'b0;
    push(8'hEE);
    chk("R9 full inactive no overrun", overrunPulse, 0);
    rxActive = 1'b1;
    flush();
  endtask

  task automatic t_flush();
    setThr(6'd3);
    for (int i = 0; i < 16; i++) push(8'h70 + 8'(i));
    chk("R10 pre full", fullLevel, 1);
    chk("R10 pre trig", trigLevel, 1);
    rxActive = 1'b0;
    flush();
    chk("R10 empty", emptyLevel, 1);
    chk("R10 full cleared", fullLevel, 0);
    chk("R10 trig cleared", trigLevel, 0);
    rxActive = 1'b1;
    for (int i = 0; i < 5; i++) begin tick(); chk("R10 timeout cancelled", timeoutPulse, 0); end
    pop(); chk("R10 pop after flush reads 0", lastPop, 0);
    setThr(6'd32);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_full_overrun();
    t_order_empty();
    t_trigger();
    t_simul();
    t_timeout();
    t_inactive();
    t_flush();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule